// File: doc/BRIEF.md
# Memory-Mapped Bus Protocol Watchdog

This block is a passive observer for a pipelined memory-mapped bus that carries read, write, waitrequest, readdatavalid and burst-length signals. It drives none of those signals. It follows the read bursts in flight, the progress of write bursts and the length of stall runs. When any of these exceeds a limit fixed by a parameter, it raises a sticky error flag.

Each error condition has its own flag bit. A 3-bit cause code records the first condition that was seen. Flags and the cause code hold until a one-cycle clear pulse or a synchronous reset. For slaves that have no readdatavalid, a parameter selects a fixed-latency mode. In that mode each read is taken to return a set number of cycles after it is accepted.

Top module: `mm_bus_watchdog`

## Requirements
- R1: `rst` (synchronous, active high) clears all counters, tallies, flags and the cause code. A one-cycle `err_clr` pulse clears `err_flags` and `err_cause` to 0 on the next edge, and it takes precedence over any error raised in that same cycle.
- R2: If `bus_waitreq` is high for WAIT_LIMIT consecutive cycles, flag bit 0 is set (cause code 1). Any cycle with `bus_waitreq` low restarts the run.
- R3: A read is accepted in a cycle with `bus_read` high and `bus_waitreq` low, and it adds `bus_burst` beats to the tally (a burst value of 0 counts as 1). Each `bus_rdvalid` cycle retires one beat of the oldest outstanding read. The read stops being outstanding when its last beat returns.
- R4: If at least one read is outstanding for RD_LIMIT consecutive cycles with no beat returned, flag bit 1 is set (cause code 2). Every returned beat restarts that count.
- R5: A write is accepted in a cycle with `bus_write` high and `bus_waitreq` low. Once the first beat of a multi-beat write burst is accepted, the remaining beats must all be accepted within WR_LIMIT cycles. Otherwise flag bit 2 is set (cause code 3).
- R6: If a read is accepted while MAX_PEND reads are already outstanding (not counting one that completes in that same cycle), flag bit 3 is set (cause code 4).
- R7: A `bus_rdvalid` cycle with no read outstanding sets flag bit 4 (cause code 5). A read accepted in that same cycle does not count as outstanding.
- R8: With HAS_RDVALID=0, `bus_rdvalid` has no effect. Each accepted read counts as outstanding until exactly FIXED_LAT cycles after its acceptance, and the read timeout of R4 is not applied.
- R9: Flags accumulate until cleared. `err_cause` keeps the code of the first error. When several errors arise in the same cycle, the lowest code wins, and code 0 means no error.
- R10: `err_any` is high exactly when some bit of `err_flags` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_clr | input | 1 | Clears flags and cause code |
| bus_read | input | 1 | Observed read request |
| bus_write | input | 1 | Observed write request |
| bus_waitreq | input | 1 | Observed slave stall |
| bus_rdvalid | input | 1 | Observed read beat return |
| bus_burst | input | BURST_W | Observed burst length |
| err_flags | output | 5 | Sticky error flags, bit n means cause code n+1 |
| err_cause | output | 3 | Code of the first error since clear |
| err_any | output | 1 | OR of all flags |

## Verification
Two situations are hard to reach from the ports. The first is a read timeout that only fires after the count has been restarted by a returned beat. The bench reaches it by returning one beat of a two-beat read and then going silent, and it probes the cycle just before the limit and the cycle at the limit. The second is an exact beat tally over many random bursts with random acceptance stalls. The bench proves the tally by sending one extra readdatavalid at the end, which must be reported as unexpected. A stall error and an unexpected beat are also forced into the same cycle to check that the lowest cause code wins.

// File: rtl/mmwd_pkg.sv
package mmwd_pkg;

    localparam int NUM_ERR = 5;

    typedef enum logic [2:0] {
        CAUSE_NONE       = 3'd0,
        CAUSE_STALL      = 3'd1,
        CAUSE_RD_TIMEOUT = 3'd2,
        CAUSE_WR_TIMEOUT = 3'd3,
        CAUSE_PEND_OVF   = 3'd4,
        CAUSE_ORPHAN     = 3'd5
    } cause_e;

    // bit 0 is stall, bit 4 is orphan beat
    typedef struct packed {
        logic orphan;
        logic pend_ovf;
        logic wr_timeout;
        logic rd_timeout;
        logic stall;
    } err_vec_t;

    function automatic cause_e pick_cause(input err_vec_t ev);
        if (ev.stall)      return CAUSE_STALL;
        if (ev.rd_timeout) return CAUSE_RD_TIMEOUT;
        if (ev.wr_timeout) return CAUSE_WR_TIMEOUT;
        if (ev.pend_ovf)   return CAUSE_PEND_OVF;
        if (ev.orphan)     return CAUSE_ORPHAN;
        return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/mmwd_run_timer.sv
module mmwd_run_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic restart_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active_i || restart_i)
            cnt_q <= '0;
        else if (cnt_q != CW'(LIMIT))
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = active_i && !restart_i && (cnt_q == CW'(LIMIT - 1));

    AST_TIMER_ONCE: assert property (@(posedge clk) disable iff (rst)
        expired_o |=> !expired_o); // R2
    AST_TIMER_SAT: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(LIMIT)); // R4

endmodule

// File: rtl/mmwd_read_track.sv
module mmwd_read_track #(
    parameter int BURST_W     = 4,
    parameter int MAX_PEND    = 1,
    parameter bit HAS_RDVALID = 1'b1,
    parameter int FIXED_LAT   = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_accept_i,
    input  logic               rdvalid_i,
    input  logic [BURST_W-1:0] burst_i,
    output logic               pending_o,
    output logic               beat_ret_o,
    output logic               pend_ovf_o,
    output logic               orphan_o
);
    generate
        if (HAS_RDVALID) begin : g_rdvalid
            localparam int DEPTH = (MAX_PEND > 0) ? MAX_PEND : 1;
            localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
            localparam int CW    = $clog2(DEPTH + 2);

            logic [BURST_W-1:0] left_q [DEPTH];
            logic [PW-1:0]      head_q, tail_q;
            logic [CW-1:0]      occ_q, occ_after;
            logic [BURST_W-1:0] beats_in;
            logic               pop, push;

            function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
                return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
            endfunction

            assign beats_in   = (burst_i == '0) ? BURST_W'(1) : burst_i;
            assign orphan_o   = rdvalid_i && (occ_q == '0);
            assign beat_ret_o = rdvalid_i && (occ_q != '0);
            assign pop        = beat_ret_o && (left_q[head_q] == BURST_W'(1));
            assign occ_after  = occ_q - CW'(pop);
            assign pend_ovf_o = rd_accept_i && (occ_after >= CW'(MAX_PEND));
            assign push       = rd_accept_i && !pend_ovf_o;
            assign pending_o  = (occ_q != '0);

            always_ff @(posedge clk) begin
                if (rst) begin
                    head_q <= '0;
                    tail_q <= '0;
                    occ_q  <= '0;
                end else begin
                    if (pop)  head_q <= adv(head_q);
                    if (push) tail_q <= adv(tail_q);
                    occ_q <= occ_after + CW'(push);
                end
            end

            always_ff @(posedge clk) begin
                if (beat_ret_o && !pop)
                    left_q[head_q] <= left_q[head_q] - 1'b1;
                if (push)
                    left_q[tail_q] <= beats_in;
            end

            AST_PEND_BOUND: assert property (@(posedge clk) disable iff (rst)
                occ_q <= CW'(DEPTH)); // R6
            AST_ORPHAN_EMPTY: assert property (@(posedge clk) disable iff (rst)
                (orphan_o && !rd_accept_i) |=> occ_q == '0); // R7
        end else begin : g_fixed
            assign beat_ret_o = 1'b0;
            assign orphan_o   = 1'b0;
            assign pending_o  = 1'b0;
            if (FIXED_LAT == 0) begin : g_zero
                assign pend_ovf_o = 1'b0;
            end else begin : g_pipe
                logic [FIXED_LAT-1:0] pipe_q;
                int unsigned          inflight;

                assign inflight   = $countones(pipe_q) - int'(pipe_q[FIXED_LAT-1]);
                assign pend_ovf_o = rd_accept_i && (inflight >= MAX_PEND);

                always_ff @(posedge clk) begin
                    if (rst) pipe_q <= '0;
                    else     pipe_q <= (pipe_q << 1) | FIXED_LAT'(rd_accept_i);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/mmwd_write_track.sv
module mmwd_write_track #(
    parameter int BURST_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_accept_i,
    input  logic [BURST_W-1:0] burst_i,
    output logic               busy_o,
    output logic               done_o
);
    logic [BURST_W-1:0] left_q;
    logic [BURST_W-1:0] beats_in;
    logic               busy_q;

    assign beats_in = (burst_i == '0) ? BURST_W'(1) : burst_i;
    assign done_o   = busy_q && wr_accept_i && (left_q == BURST_W'(1));
    assign busy_o   = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            left_q <= '0;
        end else if (busy_q) begin
            if (wr_accept_i) begin
                left_q <= left_q - 1'b1;
                if (left_q == BURST_W'(1)) busy_q <= 1'b0;
            end
        end else if (wr_accept_i && beats_in > BURST_W'(1)) begin
            busy_q <= 1'b1;
            left_q <= beats_in - 1'b1;
        end
    end

    AST_WR_LEFT: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> left_q != '0); // R5
    AST_WR_DONE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_q); // R5

endmodule

// File: rtl/mm_bus_watchdog.sv
module mm_bus_watchdog
    import mmwd_pkg::*;
#(
    parameter int BURST_W     = 4,
    parameter int WAIT_LIMIT  = 1024,
    parameter int RD_LIMIT    = 100,
    parameter int WR_LIMIT    = 100,
    parameter int MAX_PEND    = 1,
    parameter bit HAS_RDVALID = 1'b1,
    parameter int FIXED_LAT   = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               err_clr,
    input  logic               bus_read,
    input  logic               bus_write,
    input  logic               bus_waitreq,
    input  logic               bus_rdvalid,
    input  logic [BURST_W-1:0] bus_burst,
    output logic [NUM_ERR-1:0] err_flags,
    output logic [2:0]         err_cause,
    output logic               err_any
);
    logic     rd_accept, wr_accept;
    logic     rd_pending, beat_ret, wr_busy, wr_done;
    err_vec_t ev, flags_q;
    cause_e   cause_q;

    assign rd_accept = bus_read  && !bus_waitreq;
    assign wr_accept = bus_write && !bus_waitreq;

    mmwd_run_timer #(.LIMIT(WAIT_LIMIT)) u_stall_timer (
        .clk(clk), .rst(rst), .active_i(bus_waitreq), .restart_i(1'b0),
        .expired_o(ev.stall));

    mmwd_read_track #(
        .BURST_W(BURST_W), .MAX_PEND(MAX_PEND),
        .HAS_RDVALID(HAS_RDVALID), .FIXED_LAT(FIXED_LAT)
    ) u_rd_track (
        .clk(clk), .rst(rst), .rd_accept_i(rd_accept), .rdvalid_i(bus_rdvalid),
        .burst_i(bus_burst), .pending_o(rd_pending), .beat_ret_o(beat_ret),
        .pend_ovf_o(ev.pend_ovf), .orphan_o(ev.orphan));

    mmwd_run_timer #(.LIMIT(RD_LIMIT)) u_rd_timer (
        .clk(clk), .rst(rst), .active_i(rd_pending), .restart_i(beat_ret),
        .expired_o(ev.rd_timeout));

    mmwd_write_track #(.BURST_W(BURST_W)) u_wr_track (
        .clk(clk), .rst(rst), .wr_accept_i(wr_accept), .burst_i(bus_burst),
        .busy_o(wr_busy), .done_o(wr_done));

    mmwd_run_timer #(.LIMIT(WR_LIMIT)) u_wr_timer (
        .clk(clk), .rst(rst), .active_i(wr_busy), .restart_i(wr_done),
        .expired_o(ev.wr_timeout));

    always_ff @(posedge clk) begin
        if (rst || err_clr) begin
            flags_q <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            flags_q <= flags_q | ev;
            if (cause_q == CAUSE_NONE && ev != '0)
                cause_q <= pick_cause(ev);
        end
    end

    assign err_flags = flags_q;
    assign err_cause = cause_q;
    assign err_any   = |flags_q;

    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> (flags_q == '0 && cause_q == CAUSE_NONE)); // R1
    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cause_q != CAUSE_NONE && !err_clr) |=> cause_q == $past(cause_q)); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !err_clr |=> (flags_q & $past(flags_q)) == $past(flags_q)); // R9
    AST_CAUSE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        cause_q != CAUSE_NONE |-> flags_q[cause_q - 3'd1]); // R9

endmodule

// File: tb/mm_bus_watchdog_tb_top.sv
module mm_bus_watchdog_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BW     = 4;
    localparam int WAIT_L = 12;
    localparam int RD_L   = 8;
    localparam int WR_L   = 8;
    localparam int PEND   = 2;
    localparam int LAT    = 3;

    logic clk = 1'b0;
    logic rst, clr, rd, wr, wq, rv;
    logic [BW-1:0] bc;
    logic [4:0] f_a, f_b;
    logic [2:0] c_a, c_b;
    logic any_a, any_b;
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mm_bus_watchdog #(.BURST_W(BW), .WAIT_LIMIT(WAIT_L), .RD_LIMIT(RD_L),
        .WR_LIMIT(WR_L), .MAX_PEND(PEND), .HAS_RDVALID(1'b1), .FIXED_LAT(0)) dut_i (
        .clk(clk), .rst(rst), .err_clr(clr), .bus_read(rd), .bus_write(wr),
        .bus_waitreq(wq), .bus_rdvalid(rv), .bus_burst(bc),
        .err_flags(f_a), .err_cause(c_a), .err_any(any_a));

    mm_bus_watchdog #(.BURST_W(BW), .WAIT_LIMIT(WAIT_L), .RD_LIMIT(RD_L),
        .WR_LIMIT(WR_L), .MAX_PEND(PEND), .HAS_RDVALID(1'b0), .FIXED_LAT(LAT)) dut_fix_i (
        .clk(clk), .rst(rst), .err_clr(clr), .bus_read(rd), .bus_write(wr),
        .bus_waitreq(wq), .bus_rdvalid(rv), .bus_burst(bc),
        .err_flags(f_b), .err_cause(c_b), .err_any(any_b));

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic tick(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic idle();
        rd = 0; wr = 0; wq = 0; rv = 0; bc = 4'd1; clr = 0;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // expected {cause, flags}: cause is the lowest set flag index + 1
    function automatic logic [7:0] expect_err(input logic [4:0] fl);
        for (int i = 0; i < 5; i++)
            if (fl[i]) return {3'(i + 1), fl};
        return 8'h00;
    endfunction

    task automatic do_reset();
        idle(); rst = 1; tick(2); rst = 0;
    endtask

    task automatic pulse_clr();
        clr = 1; tick(); clr = 0;
    endtask

    task automatic rd_issue(input logic [BW-1:0] b);
        rd = 1; bc = b; tick(); rd = 0; bc = 4'd1;
    endtask

    task automatic beat();
        rv = 1; tick(); rv = 0;
    endtask

    task automatic wr_beat(input logic [BW-1:0] b);
        wr = 1; bc = b; tick(); wr = 0; bc = 4'd1;
    endtask

    task automatic hold_wait(input int n);
        wq = 1; tick(n); wq = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        check("R1 reset", {c_a, f_a}, 8'h00);
        check("R1 reset fixed", {c_b, f_b}, 8'h00);
        check("R10 idle", {7'd0, any_a}, 8'h00);

        // stall run one short of the limit, then exactly at the limit
        hold_wait(WAIT_L - 1); tick();
        check("R2 short stall", {c_a, f_a}, 8'h00);
        hold_wait(WAIT_L);
        check("R2 stall", {c_a, f_a}, expect_err(5'b00001));
        check("R10 any", {7'd0, any_a}, 8'h01);

        // later orphan beat keeps first cause
        beat();
        check("R9 sticky", {c_a, f_a}, 8'h31);
        check("R7 orphan", {7'd0, f_a[4]}, 8'h01);
        check("R8 rdvalid ignored", {c_b, f_b}, expect_err(5'b00001));

        // clear wins over same-cycle orphan
        clr = 1; rv = 1; tick(); clr = 0; rv = 0;
        check("R1 clear", {c_a, f_a}, 8'h00);
        check("R1 clear fixed", {c_b, f_b}, 8'h00);

        // read timeout restarted by a beat
        rd_issue(4'd2); tick(RD_L - 1);
        check("R4 before limit", {c_a, f_a}, 8'h00);
        beat(); tick(RD_L - 1);
        check("R4 restarted", {c_a, f_a}, 8'h00);
        tick();
        check("R4 timeout", {c_a, f_a}, expect_err(5'b00010));
        check("R8 no rd timeout", {c_b, f_b}, 8'h00);
        pulse_clr();
        beat(); tick();
        check("R3 last beat", {c_a, f_a}, 8'h00);
        beat();
        check("R7 orphan after", {c_a, f_a}, expect_err(5'b10000));
        pulse_clr();

        // overflow: three back-to-back reads with limit two
        rd_issue(4'd1); rd_issue(4'd1); rd_issue(4'd1);
        check("R6 overflow", {c_a, f_a}, expect_err(5'b01000));
        check("R8 fixed overflow", {c_b, f_b}, expect_err(5'b01000));
        beat(); beat(); tick();
        check("R3 two retire", {c_a, f_a}, expect_err(5'b01000));
        do_reset();

        // fixed latency: reads at t, t+1, t+3 stay within two in flight
        rd_issue(4'd1); rd_issue(4'd1); tick(); rd_issue(4'd1); tick(4);
        check("R8 spaced reads", {c_b, f_b}, 8'h00);
        do_reset();

        // write burst finishing exactly at the limit, then one timing out
        wr_beat(4'd4); tick(WR_L - 3);
        wr_beat(4'd4); wr_beat(4'd4); wr_beat(4'd4);
        check("R5 write in time", {c_a, f_a}, 8'h00);
        wq = 1; wr_beat(4'd4); wq = 0;
        check("R3 write not accepted", {c_a, f_a}, 8'h00);
        wr_beat(4'd4); tick(WR_L);
        check("R5 write timeout", {c_a, f_a}, expect_err(5'b00100));
        wr_beat(4'd4); wr_beat(4'd4); wr_beat(4'd4);
        pulse_clr();

        // stall and orphan in the same cycle
        wq = 1; tick(WAIT_L - 1); rv = 1; tick(); rv = 0; wq = 0;
        check("R9 same cycle", {c_a, f_a}, 8'h31);
        do_reset();

        // random stall runs
        begin
            int maxrun = 0;
            for (int i = 0; i < 40; i++) begin
                int len = $urandom_range(1, WAIT_L + 1);
                if (len > maxrun) maxrun = len;
                hold_wait(len); tick();
            end
            check("R2 random stalls", {c_a, f_a},
                  expect_err({4'b0000, maxrun >= WAIT_L}));
        end
        do_reset();

        // random read bursts with acceptance stalls
        for (int i = 0; i < 25; i++) begin
            int b = $urandom_range(1, 4);
            int s = $urandom_range(0, 3);
            rd = 1; bc = 4'(b); wq = 1; tick(s); wq = 0; tick(); rd = 0; bc = 4'd1;
            for (int k = 0; k < b; k++) begin
                tick($urandom_range(0, 6));
                beat();
            end
        end
        check("R3 random reads", {c_a, f_a}, 8'h00);
        beat();
        check("R7 tally exact", {c_a, f_a}, expect_err(5'b10000));

        report();
        $finish;
    end

endmodule